// File: doc/BRIEF.md
# Broadcast Token-Bucket Rate Limiter

This block sits on the receive byte stream of a network port and bounds how much broadcast traffic gets through. Frames arrive one byte per valid beat. A start marker and an end marker qualify the first and last beats. A frame counts as broadcast when its first six bytes all equal 0xFF. Every byte of a broadcast frame is paid for with one token from a bucket. A frame that drains the bucket to zero at any point is marked for discarding when it ends. The block decides per whole frame and never shapes or delays bytes.

A free-running cycle counter reloads the bucket to a programmed depth once every programmed interval. The depth sets the largest broadcast burst. The ratio of depth to interval sets the sustained broadcast share of the line rate. The downstream buffer discards a frame when the drop flag is high during the one-cycle frame-done pulse. The current token count is available on a port.

Top module: `bcast_rate_limiter`

## Requirements
- R1: While reset is low and in the first cycle after it, `tokens` is 0 and `frame_done` is 0.
- R2: A frame is broadcast only if it has at least six bytes and its first six bytes are all 0xFF. Any other frame leaves `tokens` unchanged and is never flagged.
- R3: With `interval` = N > 0, `tokens` is loaded with `depth` on the Nth clock edge counted from the edge where the interval counter last restarted. The load replaces the count and does not add to it. With `interval` = 0 no load happens and the counter rests at 0.
- R4: On the sixth byte of a broadcast frame, `tokens` drops by 6, and on each later byte by 1. It saturates at 0, and each change is visible after the clock edge that takes the byte.
- R5: One cycle after the end-marked beat, `frame_done` pulses high for exactly one cycle. `drop` is high with it if and only if the frame was broadcast, filtering was on, and a deduction within the frame left `tokens` at 0.
- R6: With `filt_en` = 0, frames never change `tokens` and `drop` is never high at `frame_done`.
- R7: When a load and a deduction fall on the same edge, the load wins. `tokens` equals `depth`, and that byte does not count as reaching zero.
- R8: Once a broadcast frame has reached zero, it stays flagged until its end. A load later in the same frame clears the flag neither for that frame nor for its later byte deductions.
- R9: Valid beats that arrive outside a frame, with no start marker since the last end, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_en | input | 1 | Enables broadcast limiting |
| depth | input | CNT_W | Bucket load value |
| interval | input | IVL_W | Load period in cycles, 0 disables |
| rx_valid | input | 1 | Byte beat valid |
| rx_sof | input | 1 | Beat is first byte of a frame |
| rx_eof | input | 1 | Beat is last byte of a frame |
| rx_byte | input | 8 | Received byte |
| frame_done | output | 1 | One-cycle pulse after a frame's last beat |
| drop | output | 1 | Discard decision, valid with frame_done |
| tokens | output | CNT_W | Current token count |

## Verification
The hardest case to set up from the ports is a load that lands on the very edge that takes a broadcast byte, or that lands after the frame has already reached zero. The interval counter runs freely, so its phase is normally unknown. The stimulus holds `interval` at 0, which parks the counter at 0. It then raises `interval` to 1 for exactly the one cycle in which the chosen byte is driven. This places a load on a known edge. The same method also gives exact periodic-load timing when a larger interval is written from the parked state.

// File: rtl/bcast_rate_limiter.sv
module bcast_rate_limiter #(
  parameter int CNT_W = 16,
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt_en,
  input  logic [CNT_W-1:0] depth,
  input  logic [IVL_W-1:0] interval,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_byte,
  output logic             frame_done,
  output logic             drop,
  output logic [CNT_W-1:0] tokens
);
  localparam int HDR = 6;

  logic [2:0]       idx;
  logic             ff_ok, is_bc, drop_pend;
  logic [IVL_W-1:0] ivl_cnt;

  logic             active, ff_now, hit6, bc_byte, refill, empty_hit, drop_cur;
  logic [2:0]       byte_no;
  logic [CNT_W-1:0] take, tok_sub;

  assign active   = rx_valid && (rx_sof || idx != 3'd0);
  assign byte_no  = rx_sof ? 3'd1 : (idx == 3'd7 ? 3'd7 : idx + 3'd1);
  assign ff_now   = (rx_sof || ff_ok) && (rx_byte == 8'hFF);
  assign hit6     = active && filt_en && byte_no == 3'(HDR) && ff_now;
  assign bc_byte  = active && filt_en && !rx_sof && is_bc;
  assign take     = hit6 ? CNT_W'(HDR) : (bc_byte ? CNT_W'(1) : '0);
  assign tok_sub  = (tokens > take) ? tokens - take : '0;
  assign refill   = (interval != '0) && (ivl_cnt == interval - IVL_W'(1));
  assign empty_hit = (take != '0) && !refill && (tok_sub == '0);
  assign drop_cur = ((!rx_sof && drop_pend) || empty_hit) && filt_en;

  always_ff @(posedge clk) begin
    if (!rst_n) ivl_cnt <= '0;
    else if (interval == '0 || refill) ivl_cnt <= '0;
    else ivl_cnt <= ivl_cnt + IVL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tokens <= '0;
    else if (refill) tokens <= depth;
    else if (take != '0) tokens <= tok_sub;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; ff_ok <= 1'b0; is_bc <= 1'b0; drop_pend <= 1'b0;
      frame_done <= 1'b0; drop <= 1'b0;
    end else begin
      frame_done <= active && rx_eof;
      drop       <= active && rx_eof && drop_cur;
      if (active) begin
        if (rx_eof) begin
          idx <= '0; ff_ok <= 1'b0; is_bc <= 1'b0; drop_pend <= 1'b0;
        end else begin
          idx       <= byte_no;
          ff_ok     <= ff_now;
          is_bc     <= (!rx_sof && is_bc) || hit6;
          drop_pend <= drop_cur;
        end
      end
    end
  end

  p_load_sets_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(refill) |-> tokens == $past(depth));

  p_zero_ivl_parks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(interval) == '0 |-> ivl_cnt == '0);

  p_only_load_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(refill) |-> tokens <= $past(tokens));

  p_done_after_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && frame_done |-> $past(rx_valid && rx_eof));

  p_drop_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> frame_done);

  p_off_keeps_tokens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(filt_en) && !$past(refill) |-> $stable(tokens));
endmodule

// File: tb/test_bcast_rate_limiter.sv
module test_bcast_rate_limiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        filt_en = 1'b0;
  logic [15:0] depth = '0;
  logic [15:0] interval = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        frame_done, drop;
  logic [15:0] tokens;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bcast_rate_limiter i_bcast_rate_limiter (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .depth(depth), .interval(interval),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_byte(rx_byte),
    .frame_done(frame_done), .drop(drop), .tokens(tokens)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic s, input logic e, input logic [7:0] b);
    rx_valid = 1'b1; rx_sof = s; rx_eof = e; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic load(input int d);
    depth = 16'(d); interval = 16'd1;
    @(negedge clk);
    interval = 16'd0;
  endtask

  // sends n bytes, byte 'bad_at' (1-based) is 0x00 if nonzero; checks done pulse
  task automatic frame(input int n, input int bad_at, input string req, input int exp_drop);
    for (int i = 1; i <= n; i++)
      beat(i == 1, i == n, (i == bad_at) ? 8'h00 : 8'hFF);
    check({req, " done pulse"}, int'(frame_done), 1);
    check({req, " drop"}, int'(drop), exp_drop);
    @(negedge clk);
    check({req, " done single cycle"}, int'(frame_done), 0);
  endtask

  task automatic t_reset;
    check("R1 tokens in reset", int'(tokens), 0);
    check("R1 done in reset", int'(frame_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tokens after reset", int'(tokens), 0);
    check("R1 done after reset", int'(frame_done), 0);
  endtask

  task automatic t_load_replaces;
    load(50);
    check("R3 load to depth", int'(tokens), 50);
    load(20);
    check("R3 load replaces not adds", int'(tokens), 20);
  endtask

  task automatic t_consume;
    filt_en = 1'b1;
    load(20);
    for (int i = 1; i <= 5; i++) beat(i == 1, 1'b0, 8'hFF);
    check("R4 no deduction before sixth byte", int'(tokens), 20);
    beat(1'b0, 1'b0, 8'hFF);
    check("R4 six deducted on sixth byte", int'(tokens), 14);
    for (int i = 7; i <= 9; i++) beat(1'b0, 1'b0, 8'h55);
    check("R4 one per later byte", int'(tokens), 11);
    beat(1'b0, 1'b1, 8'h55);
    check("R5 kept frame done", int'(frame_done), 1);
    check("R5 kept frame not dropped", int'(drop), 0);
    check("R4 ten-byte total", int'(tokens), 10);
    @(negedge clk);
    frame(10, 0, "R5 exact drain", 1);
    check("R4 saturate at zero", int'(tokens), 0);
    frame(8, 0, "R5 empty bucket", 1);
    check("R4 stays zero", int'(tokens), 0);
  endtask

  task automatic t_non_bcast;
    load(20);
    frame(12, 3, "R2 non-ff header", 0);
    check("R2 tokens kept non-ff", int'(tokens), 20);
    frame(12, 6, "R2 sixth byte differs", 0);
    check("R2 tokens kept sixth", int'(tokens), 20);
    frame(5, 0, "R2 short frame", 0);
    check("R2 tokens kept short", int'(tokens), 20);
  endtask

  task automatic t_disabled;
    filt_en = 1'b0;
    frame(30, 0, "R6 disabled", 0);
    check("R6 tokens untouched", int'(tokens), 20);
    filt_en = 1'b1;
  endtask

  task automatic t_period;
    repeat (40) @(negedge clk);
    check("R3 zero interval no load", int'(tokens), 20);
    depth = 16'd33; interval = 16'd8;
    repeat (7) @(negedge clk);
    check("R3 before eighth edge", int'(tokens), 20);
    @(negedge clk);
    check("R3 on eighth edge", int'(tokens), 33);
    depth = 16'd44;
    repeat (7) @(negedge clk);
    check("R3 second period pending", int'(tokens), 33);
    @(negedge clk);
    check("R3 second period", int'(tokens), 44);
    interval = 16'd0;
    @(negedge clk);
  endtask

  task automatic t_load_wins;
    load(9);
    for (int i = 1; i <= 6; i++) beat(i == 1, 1'b0, 8'hFF);
    check("R4 after header", int'(tokens), 3);
    beat(1'b0, 1'b0, 8'h11);
    beat(1'b0, 1'b0, 8'h11);
    check("R4 one left", int'(tokens), 1);
    depth = 16'd15; interval = 16'd1;
    beat(1'b0, 1'b0, 8'h11);
    interval = 16'd0;
    check("R7 load wins over deduction", int'(tokens), 15);
    beat(1'b0, 1'b1, 8'h11);
    check("R7 not counted as drained", int'(drop), 0);
    check("R7 deduction after load", int'(tokens), 14);
    @(negedge clk);
  endtask

  task automatic t_sticky;
    load(8);
    for (int i = 1; i <= 8; i++) beat(i == 1, 1'b0, 8'hFF);
    check("R8 drained", int'(tokens), 0);
    depth = 16'd20; interval = 16'd1;
    beat(1'b0, 1'b0, 8'hAA);
    interval = 16'd0;
    check("R8 load mid frame", int'(tokens), 20);
    beat(1'b0, 1'b0, 8'hAA);
    beat(1'b0, 1'b0, 8'hAA);
    beat(1'b0, 1'b1, 8'hAA);
    check("R8 flag sticky", int'(drop), 1);
    check("R8 later bytes deducted", int'(tokens), 17);
    @(negedge clk);
  endtask

  task automatic t_stray;
    int seen = 0;
    for (int i = 0; i < 10; i++) begin
      beat(1'b0, i == 9, 8'hFF);
      seen += int'(frame_done);
    end
    @(negedge clk);
    seen += int'(frame_done);
    check("R9 stray beats no done", seen, 0);
    check("R9 stray beats tokens kept", int'(tokens), 17);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_load_replaces();
    t_consume();
    t_non_bcast();
    t_disabled();
    t_period();
    t_load_wins();
    t_sticky();
    t_stray();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule